// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block is the clocked control core of a half-bridge gate driver. It takes one PWM command and drives two gate enables: one for the high-side switch and one for the low-side switch of a synchronous buck stage. External comparators have already sorted the PWM command into three bands. The block receives it as two flags: above the upper threshold, and below the lower threshold. When neither flag or both flags are set, the command is in the mid-level band.

Two more comparator flags report whether each gate has actually discharged. These flags set an adaptive dead time: a gate is switched on only after the opposite gate is seen to be off. A count of fixed delay cycles is not used.

A mid-level command that lasts for a programmable holdoff turns both gates off. The gates stay off until the command leaves that band. When forced-continuous mode is not selected, the block emulates a diode: an inductor zero-current flag ends the low-side pulse, but only after a minimum low-side on time. A supply-good input keeps both gates off while the bias supply is not ready. Every input passes through a synchronizer of SYNC_STAGES flops.

Top module: `gate_seq`

## Requirements
- R1: While reset is asserted, and after reset while no high or low command has been seen, both gate enables are low.
- R2: The upper and lower enables are never high in the same cycle.
- R3: On a high command, the lower enable drops first. The upper enable rises only after the lower-gate-discharged flag has been seen true. While the flag stays false, both enables stay low.
- R4: On a low command, the upper enable drops first. The lower enable rises only after the upper-gate-discharged flag has been seen true. While the flag stays false, both enables stay low.
- R5: A mid-level command that lasts fewer than HOLDOFF_CYC synchronized cycles has no effect. A gate that is on stays on.
- R6: A mid-level command that lasts HOLDOFF_CYC synchronized cycles or more forces both enables low. They stay low for as long as the command stays mid-level.
- R7: After shutdown, a high or low command resumes normal sequencing as in R3 and R4.
- R8: With force_ccm low, a zero-current flag during the low-side pulse turns the lower enable off. It stays off while the command stays low, and the next high-then-low command turns it on again.
- R9: In diode emulation the lower enable stays high for at least MIN_ON_CYC cycles. If the zero-current flag is held true from the start of the pulse, the pulse lasts exactly MIN_ON_CYC cycles.
- R10: With force_ccm high, the zero-current flag is ignored. If force_ccm rises while the lower gate is parked off under a low command, the lower enable comes back on without waiting for a PWM edge.
- R11: While supply_ok is low, both enables are low. When supply_ok returns, sequencing follows the present command.
- R12: With SYNC_STAGES=2, an input change made between clock edges reaches the enables at the third rising edge after the change, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_hi_flag | input | 1 | PWM above its upper threshold |
| pwm_lo_flag | input | 1 | PWM below its lower threshold (neither flag or both flags means mid-level) |
| lg_low_flag | input | 1 | Low-side gate has fallen below its turn-off threshold |
| ug_low_flag | input | 1 | High-side gate-to-source voltage has fallen below its turn-off threshold |
| zero_cur_flag | input | 1 | Inductor current has reached zero |
| force_ccm | input | 1 | 1 forces continuous conduction; 0 allows diode emulation |
| supply_ok | input | 1 | Bias supply is at or above its power-on level |
| ug_en | output | 1 | High-side gate enable |
| lg_en | output | 1 | Low-side gate enable |

## Verification
The sequencer state is visible only through the two enables.

- A wrong state usually shows as an enable that fails to rise after a discharged flag, or one that rises without that flag. It shows at the third edge after the input change.
- A holdoff or minimum-on counter that is off by one makes the shutdown or the diode-emulation cut-off one cycle early or late. The bench therefore measures the length of the low-side pulse and drives mid-level windows of exactly HOLDOFF_CYC-1 and HOLDOFF_CYC cycles.
- A state that fails to leave the parked or shutdown state shows as an enable that stays low for the whole of the next command.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

   typedef enum logic [1:0] {
      LVL_MID  = 2'd0,
      LVL_LOW  = 2'd1,
      LVL_HIGH = 2'd2
   } pwm_lvl_t;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_HS_WAIT = 3'd1,
      ST_HS_ON   = 3'd2,
      ST_LS_WAIT = 3'd3,
      ST_LS_ON   = 3'd4,
      ST_LS_PARK = 3'd5,
      ST_SHDN    = 3'd6
   } seq_state_t;

   function automatic pwm_lvl_t decode_lvl(input logic above, input logic below);
      if (above && !below)      return LVL_HIGH;
      else if (below && !above) return LVL_LOW;
      else                      return LVL_MID;
   endfunction

endpackage

// File: rtl/gate_seq_sync.sv
module gate_seq_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gate_seq_timer.sv
module gate_seq_timer #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic done
);
   if (LIMIT <= 1) begin : g_none
      wire unused_tie = &{1'b0, clk, rst_n, clr, en};
      assign done = 1'b1;
   end else begin : g_cnt
      localparam int CW = $clog2(LIMIT);
      localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             cnt <= '0;
         else if (clr)           cnt <= '0;
         else if (en && !done)   cnt <= cnt + 1'b1;
      end

      assign done = (cnt == LAST);
   end
endmodule

// File: rtl/gate_seq_fsm.sv
module gate_seq_fsm
   import gate_seq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  pwm_lvl_t lvl,
   input  logic     lg_low,
   input  logic     ug_low,
   input  logic     zc,
   input  logic     fccm,
   input  logic     pok,
   input  logic     shdn_go,
   input  logic     min_done,
   output logic     ls_on,
   output logic     ug_en,
   output logic     lg_en
);
   seq_state_t st, nxt;

   always_comb begin
      nxt = st;
      if (!pok)         nxt = ST_IDLE;
      else if (shdn_go) nxt = ST_SHDN;
      else begin
         unique case (st)
            ST_IDLE, ST_SHDN: begin
               if (lvl == LVL_HIGH)     nxt = ST_HS_WAIT;
               else if (lvl == LVL_LOW) nxt = ST_LS_WAIT;
            end
            ST_HS_WAIT: begin
               if (lvl == LVL_LOW)                nxt = ST_LS_WAIT;
               else if (lvl == LVL_HIGH && lg_low) nxt = ST_HS_ON;
            end
            ST_HS_ON: begin
               if (lvl == LVL_LOW) nxt = ST_LS_WAIT;
            end
            ST_LS_WAIT: begin
               if (lvl == LVL_HIGH)               nxt = ST_HS_WAIT;
               else if (lvl == LVL_LOW && ug_low) nxt = ST_LS_ON;
            end
            ST_LS_ON: begin
               if (lvl == LVL_HIGH)                nxt = ST_HS_WAIT;
               else if (!fccm && zc && min_done)   nxt = ST_LS_PARK;
            end
            ST_LS_PARK: begin
               if (lvl == LVL_HIGH)             nxt = ST_HS_WAIT;
               else if (lvl == LVL_LOW && fccm) nxt = ST_LS_WAIT;
            end
            default: nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= nxt;
   end

   assign ls_on = (st == ST_LS_ON);
   assign ug_en = (st == ST_HS_ON);
   assign lg_en = (st == ST_LS_ON);
endmodule

// File: rtl/gate_seq.sv
module gate_seq
   import gate_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int HOLDOFF_CYC = 32,
   parameter int MIN_ON_CYC  = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_hi_flag,
   input  logic pwm_lo_flag,
   input  logic lg_low_flag,
   input  logic ug_low_flag,
   input  logic zero_cur_flag,
   input  logic force_ccm,
   input  logic supply_ok,
   output logic ug_en,
   output logic lg_en
);
   localparam int NIN = 7;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gate_seq: SYNC_STAGES must be at least 2");
   end
   if (HOLDOFF_CYC < 1) begin : g_bad_hold
      $error("gate_seq: HOLDOFF_CYC must be at least 1");
   end
   if (MIN_ON_CYC < 1) begin : g_bad_minon
      $error("gate_seq: MIN_ON_CYC must be at least 1");
   end

   logic [NIN-1:0] raw_in, syn_in;
   logic pwm_hi_s, pwm_lo_s, lg_low_s, ug_low_s, zc_s, fccm_s, pok_s;
   pwm_lvl_t lvl;
   logic mid, hold_done, min_done, ls_on, shdn_go;

   assign raw_in = {pwm_hi_flag, pwm_lo_flag, lg_low_flag, ug_low_flag,
                    zero_cur_flag, force_ccm, supply_ok};

   gate_seq_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
   );

   assign {pwm_hi_s, pwm_lo_s, lg_low_s, ug_low_s, zc_s, fccm_s, pok_s} = syn_in;
   assign lvl = decode_lvl(pwm_hi_s, pwm_lo_s);
   assign mid = (lvl == LVL_MID);

   gate_seq_timer #(.LIMIT(HOLDOFF_CYC)) u_holdoff (
      .clk(clk), .rst_n(rst_n), .clr(!mid), .en(mid), .done(hold_done)
   );

   gate_seq_timer #(.LIMIT(MIN_ON_CYC)) u_minon (
      .clk(clk), .rst_n(rst_n), .clr(!ls_on), .en(ls_on), .done(min_done)
   );

   assign shdn_go = mid & hold_done;

   gate_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .lvl(lvl),
      .lg_low(lg_low_s), .ug_low(ug_low_s), .zc(zc_s), .fccm(fccm_s),
      .pok(pok_s), .shdn_go(shdn_go), .min_done(min_done),
      .ls_on(ls_on), .ug_en(ug_en), .lg_en(lg_en)
   );
endmodule

// File: rtl/gate_seq_chk.sv
module gate_seq_chk #(
   parameter int HOLDOFF_CYC = 32,
   parameter int MIN_ON_CYC  = 80
) (
   input logic clk,
   input logic rst_n,
   input logic ug_en,
   input logic lg_en,
   input logic pwm_hi_s,
   input logic pwm_lo_s,
   input logic lg_low_s,
   input logic ug_low_s,
   input logic zc_s,
   input logic fccm_s,
   input logic pok_s
);
   wire mid_c = (pwm_hi_s == pwm_lo_s);
   wire low_c = pwm_lo_s && !pwm_hi_s;
   int unsigned mid_run, on_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mid_run <= 0;
         on_run  <= 0;
      end else begin
         if (mid_c) mid_run <= (mid_run >= HOLDOFF_CYC) ? mid_run : mid_run + 1;
         else       mid_run <= 0;
         if (lg_en) on_run <= (on_run >= MIN_ON_CYC) ? on_run : on_run + 1;
         else       on_run <= 0;
      end
   end

   p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(ug_en && lg_en));

   p_ug_after_lg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ug_en) |-> $past(lg_low_s) && !$past(lg_en));

   p_lg_after_ug_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lg_en) |-> $past(ug_low_s) && !$past(ug_en));

   p_no_early_shdn_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ug_en) |-> $past(low_c) || !$past(pok_s) ||
                       ($past(mid_c) && $past(mid_run) >= HOLDOFF_CYC - 1));

   p_shdn_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mid_c && mid_run >= HOLDOFF_CYC - 1) |=> !ug_en && !lg_en);

   p_de_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(lg_en) && $past(low_c) && $past(pok_s)) |-> $past(!fccm_s && zc_s));

   p_min_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(lg_en) && $past(low_c) && $past(pok_s)) |-> on_run >= MIN_ON_CYC);

   p_supply_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !pok_s |=> !ug_en && !lg_en);
endmodule

bind gate_seq gate_seq_chk #(.HOLDOFF_CYC(HOLDOFF_CYC), .MIN_ON_CYC(MIN_ON_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .ug_en(ug_en), .lg_en(lg_en),
   .pwm_hi_s(pwm_hi_s), .pwm_lo_s(pwm_lo_s), .lg_low_s(lg_low_s),
   .ug_low_s(ug_low_s), .zc_s(zc_s), .fccm_s(fccm_s), .pok_s(pok_s)
);

// File: tb/tb_gate_seq.sv
module tb_gate_seq;
   localparam int HOLD  = 8;
   localparam int MINON = 10;
   localparam int NV    = 12;
   localparam int VHOLD = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwm_hi = 1'b0, pwm_lo = 1'b0, lg_low = 1'b0, ug_low = 1'b0;
   logic zc = 1'b0, fccm = 1'b1, pok = 1'b0;
   logic ug_en, lg_en;
   int checks = 0, fails = 0, both_on = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gate_seq #(.SYNC_STAGES(2), .HOLDOFF_CYC(HOLD), .MIN_ON_CYC(MINON)) dut (
      .clk(clk), .rst_n(rst_n), .pwm_hi_flag(pwm_hi), .pwm_lo_flag(pwm_lo),
      .lg_low_flag(lg_low), .ug_low_flag(ug_low), .zero_cur_flag(zc),
      .force_ccm(fccm), .supply_ok(pok), .ug_en(ug_en), .lg_en(lg_en)
   );

   // entry: {hi, lo, lg_low, ug_low, zc, fccm, pok, exp_ug, exp_lg}
   localparam logic [8:0] VEC [NV] = '{
      9'b0_1_1_1_0_1_1_0_1,  // R4 low command, upper discharged -> lower on
      9'b1_0_0_1_0_1_1_0_0,  // R3 high command, lower not yet discharged
      9'b1_0_1_1_0_1_1_1_0,  // R3 lower discharged -> upper on
      9'b0_1_1_0_0_1_1_0_0,  // R4 low command, upper not yet discharged
      9'b0_1_1_1_0_1_1_0_1,  // R4 upper discharged -> lower on
      9'b0_1_1_1_1_1_1_0_1,  // R10 zero current ignored in forced mode
      9'b0_1_1_1_1_0_1_0_0,  // R8 emulation cuts lower gate
      9'b0_1_1_1_0_0_1_0_0,  // R8 stays parked while command low
      9'b0_1_1_1_0_1_1_0_1,  // R10 forced mode re-enables at once
      9'b0_1_1_1_0_1_0_0_0,  // R11 supply lost
      9'b1_0_1_1_0_1_1_1_0,  // R11 supply back, high command
      9'b0_1_1_1_0_1_1_0_1   // R4 back to low side
   };
   localparam int VREQ [NV] = '{4, 3, 3, 4, 4, 10, 8, 8, 10, 11, 11, 4};

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [6:0] v);
      {pwm_hi, pwm_lo, lg_low, ug_low, zc, fccm, pok} = v;
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   always @(negedge clk) if (rst_n && ug_en && lg_en) both_on++;

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         summary();
      end
   end

   initial begin
      int cnt;
      // R1 reset state
      cycles(3);
      check(!ug_en && !lg_en, "R1", "enables in reset", {ug_en, lg_en}, 0);
      pok = 1'b1;
      rst_n = 1'b1;
      cycles(HOLD - 3);
      check(!ug_en && !lg_en, "R1", "enables idle after reset", {ug_en, lg_en}, 0);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][8:2]);
         cycles(VHOLD);
         check({ug_en, lg_en} == VEC[i][1:0], $sformatf("R%0d", VREQ[i]),
               $sformatf("vector %0d", i), {ug_en, lg_en}, VEC[i][1:0]);
      end

      // R12 latency: from upper on, low command
      drive(7'b1_0_1_1_0_1_1);
      cycles(8);
      drive(7'b0_1_1_1_0_1_1);
      cycles(2);
      check(ug_en == 1'b1, "R12", "upper after two edges", ug_en, 1);
      cycles(1);
      check(ug_en == 1'b0, "R12", "upper after third edge", ug_en, 0);
      cycles(6);

      // R9 exact minimum on time with zero current held, R8 parked after
      drive(7'b1_0_1_1_1_0_1);
      cycles(8);
      drive(7'b0_1_1_1_1_0_1);
      cnt = 0;
      for (int k = 0; k < 40; k++) begin
         cycles(1);
         if (lg_en) cnt++;
      end
      check(cnt == MINON, "R9", "low-side pulse length", cnt, MINON);
      check(lg_en == 1'b0, "R8", "lower parked under low command", lg_en, 0);

      // R8 re-entry on next high-then-low command
      drive(7'b1_0_1_1_1_0_1);
      cycles(8);
      drive(7'b0_1_1_1_1_0_1);
      cnt = 0;
      for (int k = 0; k < 40; k++) begin
         cycles(1);
         if (lg_en) cnt++;
      end
      check(cnt == MINON, "R8", "pulse after new falling command", cnt, MINON);

      // R5 mid window one cycle short of holdoff
      drive(7'b1_0_1_1_0_1_1);
      cycles(8);
      cnt = 0;
      pwm_hi = 1'b0;
      for (int k = 0; k < 20; k++) begin
         if (k == HOLD - 1) pwm_hi = 1'b1;
         cycles(1);
         if (!ug_en) cnt++;
      end
      check(cnt == 0, "R5", "upper low cycles, short mid", cnt, 0);

      // R6 mid window exactly holdoff
      cnt = 0;
      pwm_hi = 1'b0;
      for (int k = 0; k < 20; k++) begin
         if (k == HOLD) pwm_hi = 1'b1;
         cycles(1);
         if (!ug_en) cnt++;
      end
      check(cnt > 0, "R6", "upper dropped, full holdoff", cnt, 1);

      // R6 long shutdown, R7 exits
      pwm_hi = 1'b0;
      cycles(30);
      check(!ug_en && !lg_en, "R6", "both low in long mid", {ug_en, lg_en}, 0);
      drive(7'b0_1_1_1_0_1_1);
      cycles(6);
      check(lg_en == 1'b1, "R7", "lower on after shutdown", lg_en, 1);
      pwm_lo = 1'b0;
      cycles(30);
      check(lg_en == 1'b0, "R6", "lower off in long mid", lg_en, 0);
      pwm_hi = 1'b1;
      cycles(6);
      check(ug_en == 1'b1, "R7", "upper on after shutdown", ug_en, 1);

      // R2 overall exclusivity
      check(both_on == 0, "R2", "cycles with both enables high", both_on, 0);

      done = 1'b1;
      summary();
   end
endmodule